// File: doc/BRIEF.md
# Paper Tape Punch I/O Controller

This block sits on a word-wide programmed-I/O bus and runs a paper tape punch. The bus presents a device code and one of five strobes: status read, condition set, condition clear, data clear and data set. The block acts only on strobes whose device code matches its own. It keeps a busy bit, a done flag, a binary-mode bit and a 3-bit interrupt channel number. It latches one character and raises an interrupt request on the chosen channel once a character has been punched.

A character is sent to the punch only when two things are true: the device is busy, which a data clear sets, and a data set has loaded a character that has not been punched yet. The punch is modelled as a valid/done handshake. The block holds the byte steady until the mechanism answers, then drops busy and sets the flag. In binary mode only the low six character bits are punched, and the top hole is always added.

Top module: `tape_punch_ctl`

## Requirements
- R1: After rst_ni is asserted, busy, flag, binary mode, channel, the pending marker and pun_valid_o are all 0, so irq_o is 0 and a status read returns 0.
- R2: A selected status read drives stat_o with binary mode on bit 5, busy on bit 4, flag on bit 3 and the channel on bits 2:0, and all other bits 0. With no selected status read, stat_o is 0.
- R3: A selected condition set ORs bus bit 5 into binary mode, bit 4 into busy and bit 3 into flag, and ORs bits 2:0 into the channel.
- R4: A selected condition clear zeroes binary mode, busy, flag and channel. If a condition set comes in the same cycle, the set is applied after the clear.
- R5: bus_rst_i does the same clearing whatever device code is on the bus. It also drops the pending marker and aborts a punch in progress.
- R6: A selected data clear zeroes the character, sets busy, clears flag and clears the pending marker. It starts no punch by itself.
- R7: A selected data set loads bus bits 7:0 into the character and sets the pending marker. pun_valid_o rises on the first clock edge after the one where busy and pending are both 1. Starting a punch consumes the pending marker.
- R8: In normal mode pun_byte_o is the 8-bit character unchanged. In binary mode it is the low six character bits with bit 7 set and bit 6 clear (the character AND 077, OR 0200). The byte is fixed when the punch starts.
- R9: pun_valid_o and pun_byte_o hold until pun_done_i is seen high on a clock edge. On that edge valid drops, busy clears and flag sets.
- R10: irq_o has one bit per channel number. Bit n is 1 only while flag is 1 and the channel equals n, with n nonzero. Bit 0 is always 0.
- R11: Every strobe except bus reset has no effect when dev_sel_i differs from DEV_CODE.
- R12: A data set loaded while the device is not busy waits. Once busy is set later, by a condition set, the stored character is punched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_rst_i | input | 1 | I/O bus reset, not qualified by device code |
| dev_sel_i | input | DEV_W | Device code on the bus |
| stat_rd_i | input | 1 | Status read strobe |
| cond_set_i | input | 1 | Condition set strobe |
| cond_clr_i | input | 1 | Condition clear strobe |
| data_clr_i | input | 1 | Data clear strobe |
| data_set_i | input | 1 | Data set strobe |
| bus_data_i | input | WORD_W | Bus data word to the device |
| stat_o | output | WORD_W | Status word, zero unless read |
| irq_o | output | 2**CHAN_W | Interrupt request, one line per channel |
| pun_valid_o | output | 1 | Punch byte valid |
| pun_byte_o | output | CHAR_W | Byte to punch |
| pun_done_i | input | 1 | Punch mechanism finished |

## Verification
The bench sends a data set while the device is idle. A design that punches on any data set would fire at once; the correct design must wait until a later condition set makes it busy. It drives a condition clear and a condition set in the same cycle, where applying them in the wrong order leaves the channel at zero. It issues strobes with a wrong device code and a bus reset with a wrong device code, so a missing qualifier or an over-qualified reset shows up in the status word. It punches binary-mode bytes with the top two bits set, where a wrong mask or a missing forced hole changes pun_byte_o. It also holds done low for several cycles to catch a design that completes early or lets the byte change.

// File: rtl/tape_punch_pkg.sv
package tape_punch_pkg;
  // bus bit positions of the condition fields
  localparam int BIN_BIT  = 5;
  localparam int BUSY_BIT = 4;
  localparam int FLAG_BIT = 3;
  localparam int RAW6_W   = 6;

  typedef struct packed {
    logic stat_rd;
    logic cond_set;
    logic cond_clr;
    logic data_clr;
    logic data_set;
  } strb_t;
endpackage

// File: rtl/tpp_decode.sv
module tpp_decode
  import tape_punch_pkg::*;
#(
  parameter int          DEV_W    = 7,
  parameter logic [DEV_W-1:0] DEV_CODE = 7'h10
) (
  input  logic [DEV_W-1:0] dev_sel_i,
  input  logic             stat_rd_i,
  input  logic             cond_set_i,
  input  logic             cond_clr_i,
  input  logic             data_clr_i,
  input  logic             data_set_i,
  output strb_t            strb_o
);
  logic hit;
  assign hit = (dev_sel_i == DEV_CODE);

  always_comb begin
    strb_o.stat_rd  = hit & stat_rd_i;
    strb_o.cond_set = hit & cond_set_i;
    strb_o.cond_clr = hit & cond_clr_i;
    strb_o.data_clr = hit & data_clr_i;
    strb_o.data_set = hit & data_set_i;
  end
endmodule

// File: rtl/tpp_regs.sv
module tpp_regs
  import tape_punch_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int CHAR_W = 8,
  parameter int CHAN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  strb_t             strb_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              start_i,
  input  logic              cmpl_i,
  output logic              bin_o,
  output logic              busy_o,
  output logic              flag_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              pend_o
);
  logic              bin_d, busy_d, flag_d, pend_d;
  logic [CHAN_W-1:0] chan_d;
  logic [CHAR_W-1:0] char_d;

  // later statements win: completion < conditions < data strobes < bus reset
  always_comb begin
    bin_d  = bin_o;
    busy_d = busy_o;
    flag_d = flag_o;
    chan_d = chan_o;
    char_d = char_o;
    pend_d = pend_o;
    if (start_i) pend_d = 1'b0;
    if (cmpl_i) begin
      busy_d = 1'b0;
      flag_d = 1'b1;
    end
    if (strb_i.cond_clr) begin
      bin_d  = 1'b0;
      busy_d = 1'b0;
      flag_d = 1'b0;
      chan_d = '0;
    end
    if (strb_i.cond_set) begin
      bin_d  = bin_d  | data_i[BIN_BIT];
      busy_d = busy_d | data_i[BUSY_BIT];
      flag_d = flag_d | data_i[FLAG_BIT];
      chan_d = chan_d | data_i[CHAN_W-1:0];
    end
    if (strb_i.data_clr) begin
      char_d = '0;
      busy_d = 1'b1;
      flag_d = 1'b0;
      pend_d = 1'b0;
    end
    if (strb_i.data_set) begin
      char_d = data_i[CHAR_W-1:0];
      pend_d = 1'b1;
    end
    if (bus_rst_i) begin
      bin_d  = 1'b0;
      busy_d = 1'b0;
      flag_d = 1'b0;
      chan_d = '0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_o  <= 1'b0;
      busy_o <= 1'b0;
      flag_o <= 1'b0;
      chan_o <= '0;
      char_o <= '0;
      pend_o <= 1'b0;
    end else begin
      bin_o  <= bin_d;
      busy_o <= busy_d;
      flag_o <= flag_d;
      chan_o <= chan_d;
      char_o <= char_d;
      pend_o <= pend_d;
    end
  end
endmodule

// File: rtl/tpp_punch.sv
module tpp_punch
  import tape_punch_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              busy_i,
  input  logic              pend_i,
  input  logic              bin_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              done_i,
  output logic              valid_o,
  output logic [CHAR_W-1:0] byte_o,
  output logic              start_o,
  output logic              cmpl_o
);
  logic [CHAR_W-1:0] bin_byte, out_byte;

  always_comb begin
    bin_byte             = '0;
    bin_byte[RAW6_W-1:0] = char_i[RAW6_W-1:0];
    bin_byte[CHAR_W-1]   = 1'b1;  // forced top hole
  end

  assign out_byte = bin_i ? bin_byte : char_i;
  assign start_o  = busy_i & pend_i & ~valid_o & ~abort_i;
  assign cmpl_o   = valid_o & done_i & ~abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      byte_o  <= '0;
    end else if (abort_i || cmpl_o) begin
      valid_o <= 1'b0;
    end else if (start_o) begin
      valid_o <= 1'b1;
      byte_o  <= out_byte;
    end
  end
endmodule

// File: rtl/tpp_irq.sv
module tpp_irq #(
  parameter int CHAN_W = 3,
  localparam int NCHAN = 1 << CHAN_W
) (
  input  logic              flag_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic [NCHAN-1:0]  irq_o
);
  assign irq_o[0] = 1'b0;  // channel 0 means disabled
  for (genvar n = 1; n < NCHAN; n++) begin : g_ch
    assign irq_o[n] = flag_i && (chan_i == CHAN_W'(n));
  end
endmodule

// File: rtl/tape_punch_ctl.sv
module tape_punch_ctl
  import tape_punch_pkg::*;
#(
  parameter int               WORD_W   = 36,
  parameter int               CHAR_W   = 8,
  parameter int               CHAN_W   = 3,
  parameter int               DEV_W    = 7,
  parameter logic [DEV_W-1:0] DEV_CODE = 7'h10,
  localparam int              NCHAN    = 1 << CHAN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic [DEV_W-1:0]  dev_sel_i,
  input  logic              stat_rd_i,
  input  logic              cond_set_i,
  input  logic              cond_clr_i,
  input  logic              data_clr_i,
  input  logic              data_set_i,
  input  logic [WORD_W-1:0] bus_data_i,
  output logic [WORD_W-1:0] stat_o,
  output logic [NCHAN-1:0]  irq_o,
  output logic              pun_valid_o,
  output logic [CHAR_W-1:0] pun_byte_o,
  input  logic              pun_done_i
);
  strb_t             strb;
  logic              bin_q, busy_q, flag_q, pend_q;
  logic [CHAN_W-1:0] chan_q;
  logic [CHAR_W-1:0] char_q;
  logic              start, cmpl;

  tpp_decode #(.DEV_W(DEV_W), .DEV_CODE(DEV_CODE)) u_dec (
    .dev_sel_i (dev_sel_i),
    .stat_rd_i (stat_rd_i),
    .cond_set_i(cond_set_i),
    .cond_clr_i(cond_clr_i),
    .data_clr_i(data_clr_i),
    .data_set_i(data_set_i),
    .strb_o    (strb)
  );

  tpp_regs #(.WORD_W(WORD_W), .CHAR_W(CHAR_W), .CHAN_W(CHAN_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_rst_i(bus_rst_i),
    .strb_i   (strb),
    .data_i   (bus_data_i),
    .start_i  (start),
    .cmpl_i   (cmpl),
    .bin_o    (bin_q),
    .busy_o   (busy_q),
    .flag_o   (flag_q),
    .chan_o   (chan_q),
    .char_o   (char_q),
    .pend_o   (pend_q)
  );

  tpp_punch #(.CHAR_W(CHAR_W)) u_punch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(bus_rst_i),
    .busy_i (busy_q),
    .pend_i (pend_q),
    .bin_i  (bin_q),
    .char_i (char_q),
    .done_i (pun_done_i),
    .valid_o(pun_valid_o),
    .byte_o (pun_byte_o),
    .start_o(start),
    .cmpl_o (cmpl)
  );

  tpp_irq #(.CHAN_W(CHAN_W)) u_irq (
    .flag_i(flag_q),
    .chan_i(chan_q),
    .irq_o (irq_o)
  );

  always_comb begin
    stat_o = '0;
    if (strb.stat_rd) begin
      stat_o[BIN_BIT]    = bin_q;
      stat_o[BUSY_BIT]   = busy_q;
      stat_o[FLAG_BIT]   = flag_q;
      stat_o[CHAN_W-1:0] = chan_q;
    end
  end
endmodule

// File: rtl/tape_punch_chk.sv
module tape_punch_chk #(
  parameter int WORD_W = 36,
  parameter int CHAR_W = 8,
  parameter int NCHAN  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_rst_i,
  input logic              stat_rd_i,
  input logic [WORD_W-1:0] stat_o,
  input logic [NCHAN-1:0]  irq_o,
  input logic              pun_valid_o,
  input logic [CHAR_W-1:0] pun_byte_o,
  input logic              pun_done_i,
  input logic              busy_q,
  input logic              flag_q,
  input logic              pend_q,
  input logic              bin_q,
  input logic              any_strb
);
  // R2
  stat_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |-> stat_o == '0);

  // R10
  irq_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o) && !irq_o[0]);

  // R7
  start_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pun_valid_o) |-> $past(busy_q && pend_q));

  // R8
  bin_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pun_valid_o) && $past(bin_q)) |-> pun_byte_o[CHAR_W-1 -: 2] == 2'b10);

  // R9
  hold_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pun_valid_o && !pun_done_i && !bus_rst_i) |=> pun_valid_o && $stable(pun_byte_o));

  // R9
  done_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pun_valid_o && pun_done_i && !bus_rst_i && !any_strb) |=> !pun_valid_o && flag_q && !busy_q);

  // R5
  bus_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> !pun_valid_o && !busy_q && !flag_q);
endmodule

bind tape_punch_ctl tape_punch_chk #(.WORD_W(WORD_W), .CHAR_W(CHAR_W), .NCHAN(NCHAN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_rst_i  (bus_rst_i),
  .stat_rd_i  (stat_rd_i),
  .stat_o     (stat_o),
  .irq_o      (irq_o),
  .pun_valid_o(pun_valid_o),
  .pun_byte_o (pun_byte_o),
  .pun_done_i (pun_done_i),
  .busy_q     (busy_q),
  .flag_q     (flag_q),
  .pend_q     (pend_q),
  .bin_q      (bin_q),
  .any_strb   (strb.cond_set | strb.cond_clr | strb.data_clr | strb.data_set)
);

// File: tb/tape_punch_ctl_tb.sv
module tape_punch_ctl_tb;
  localparam logic [6:0] DEV = 7'h10;
  localparam logic [6:0] BAD = 7'h11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst = 1'b0;
  logic [6:0]  dev = DEV;
  logic        stat_rd = 1'b0, cond_set = 1'b0, cond_clr = 1'b0;
  logic        data_clr = 1'b0, data_set = 1'b0;
  logic [35:0] bdata = '0;
  logic [35:0] stat;
  logic [7:0]  irq;
  logic        pvalid;
  logic [7:0]  pbyte;
  logic        pdone = 1'b0;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tape_punch_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst), .dev_sel_i(dev),
    .stat_rd_i(stat_rd), .cond_set_i(cond_set), .cond_clr_i(cond_clr),
    .data_clr_i(data_clr), .data_set_i(data_set), .bus_data_i(bdata),
    .stat_o(stat), .irq_o(irq), .pun_valid_o(pvalid), .pun_byte_o(pbyte),
    .pun_done_i(pdone)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // m: [0] cond_set [1] cond_clr [2] data_clr [3] data_set [4] bus reset
  task automatic strobe(input logic [4:0] m, input logic [35:0] d, input logic [6:0] ds);
    dev = ds; bdata = d;
    cond_set = m[0]; cond_clr = m[1]; data_clr = m[2]; data_set = m[3]; bus_rst = m[4];
    @(negedge clk);
    {cond_set, cond_clr, data_clr, data_set, bus_rst} = '0;
    dev = DEV; bdata = '0;
  endtask

  task automatic read_stat(input logic [6:0] ds, output logic [35:0] v);
    dev = ds; stat_rd = 1'b1;
    #1 v = stat;
    stat_rd = 1'b0; dev = DEV;
    @(negedge clk);
  endtask

  task automatic finish_punch();
    pdone = 1'b1;
    @(negedge clk);
    pdone = 1'b0;
  endtask

  task automatic t_reset();
    logic [35:0] s;
    read_stat(DEV, s);
    chk("R1 status", s, 0);
    chk("R1 irq", irq, 0);
    chk("R1 valid", pvalid, 0);
    chk("R2 idle stat_o", stat, 0);
  endtask

  task automatic t_cond();
    logic [35:0] s;
    strobe(5'b00001, 36'h0_0000_003D, DEV);
    read_stat(DEV, s);
    chk("R3 set all", s, 36'h3D);
    chk("R10 irq ch5", irq, 8'h20);
    strobe(5'b00001, 36'hF_0000_0002, DEV);
    read_stat(DEV, s);
    chk("R3 or chan", s, 36'h3F);
    chk("R10 irq ch7", irq, 8'h80);
    strobe(5'b00010, 36'h0, DEV);
    read_stat(DEV, s);
    chk("R4 clear", s, 0);
    chk("R10 irq off", irq, 0);
    strobe(5'b00011, 36'h0B, DEV);
    read_stat(DEV, s);
    chk("R4 clear then set", s, 36'h0B);
    strobe(5'b00001, 36'h08, DEV);
    strobe(5'b00010, 36'h0, DEV);
    strobe(5'b00001, 36'h08, DEV);
    read_stat(DEV, s);
    chk("R10 chan0 no irq flag", s, 36'h08);
    chk("R10 chan0 irq", irq, 0);
    strobe(5'b00010, 36'h0, DEV);
  endtask

  task automatic t_mismatch();
    logic [35:0] s;
    strobe(5'b00001, 36'h3F, BAD);
    read_stat(DEV, s);
    chk("R11 cond set ignored", s, 0);
    strobe(5'b00100, 36'h0, BAD);
    read_stat(DEV, s);
    chk("R11 data clr ignored", s, 0);
    strobe(5'b00001, 36'h17, DEV);
    strobe(5'b00010, 36'h0, BAD);
    read_stat(DEV, s);
    chk("R11 cond clr ignored", s, 36'h17);
    read_stat(BAD, s);
    chk("R11 stat read ignored", s, 0);
  endtask

  task automatic t_bus_rst();
    logic [35:0] s;
    strobe(5'b00001, 36'h3F, DEV);
    strobe(5'b10000, 36'h0, BAD);
    read_stat(DEV, s);
    chk("R5 bus reset any dev", s, 0);
    // abort in-flight punch
    strobe(5'b00100, 36'h0, DEV);
    strobe(5'b01000, 36'h55, DEV);
    wait_cyc(1);
    chk("R5 punch started", pvalid, 1);
    strobe(5'b10000, 36'h0, DEV);
    chk("R5 punch aborted", pvalid, 0);
    wait_cyc(2);
    chk("R5 no restart", pvalid, 0);
  endtask

  task automatic t_punch_normal();
    logic [35:0] s;
    strobe(5'b00001, 36'h04, DEV);
    strobe(5'b00100, 36'h0, DEV);
    read_stat(DEV, s);
    chk("R6 data clr busy", s, 36'h14);
    wait_cyc(2);
    chk("R6 no punch on clr", pvalid, 0);
    strobe(5'b01000, 36'hF_0000_00A5, DEV);
    chk("R7 latency", pvalid, 0);
    wait_cyc(1);
    chk("R7 valid", pvalid, 1);
    chk("R8 normal byte", pbyte, 8'hA5);
    wait_cyc(3);
    chk("R9 held", pvalid, 1);
    chk("R9 byte held", pbyte, 8'hA5);
    read_stat(DEV, s);
    chk("R9 still busy", s, 36'h14);
    finish_punch();
    chk("R9 valid drop", pvalid, 0);
    read_stat(DEV, s);
    chk("R9 done status", s, 36'h0C);
    chk("R10 irq ch4", irq, 8'h10);
    wait_cyc(2);
    chk("R7 pending consumed", pvalid, 0);
    strobe(5'b00100, 36'h0, DEV);
    chk("R10 irq off after clr", irq, 0);
    strobe(5'b00010, 36'h0, DEV);
  endtask

  task automatic t_punch_bin();
    strobe(5'b00001, 36'h21, DEV);
    strobe(5'b00100, 36'h0, DEV);
    strobe(5'b01000, 36'hC7, DEV);
    wait_cyc(1);
    chk("R8 binary C7", pbyte, 8'h87);
    finish_punch();
    strobe(5'b00100, 36'h0, DEV);
    strobe(5'b01000, 36'h7F, DEV);
    wait_cyc(1);
    chk("R8 binary 7F", pbyte, 8'hBF);
    chk("R10 irq bin ch1 cleared", irq, 0);
    finish_punch();
    chk("R10 irq ch1", irq, 8'h02);
    strobe(5'b00010, 36'h0, DEV);
  endtask

  task automatic t_no_busy();
    strobe(5'b01000, 36'h33, DEV);
    wait_cyc(3);
    chk("R12 no punch idle", pvalid, 0);
    strobe(5'b00001, 36'h10, DEV);
    chk("R12 latency", pvalid, 0);
    wait_cyc(1);
    chk("R12 late punch", pvalid, 1);
    chk("R12 byte", pbyte, 8'h33);
    finish_punch();
    strobe(5'b00010, 36'h0, DEV);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_cond();
    t_mismatch();
    t_bus_rst();
    t_punch_normal();
    t_punch_bin();
    t_no_busy();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule